// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts hardware events for software profiling. Six 32-bit counters each take one event from a shared event vector. That vector holds external one-cycle strobes, a latency-threshold event and a masked instruction-address match. One mode register controls all counting. It can stop counting by privilege level, by a process-mark bit, or after an interrupt has been raised. It can also hold counters 2 to 6 until counter 1 overflows.

A counter has overflowed when its top bit is set. An overflow, or a rising edge on a selected time-base bit, can raise a sticky interrupt. A separate condition output reports the same conditions whether or not the interrupt is enabled. Software programs the unit and reads it back through a plain write port and an asynchronous read port.

Top module: `evmon_unit`

## Requirements
- R1: After reset, every register read back (addresses 0 to 9) is zero, and `pm_int` and `pm_cond` are low.
- R2: A counter adds exactly one at the clock edge that ends a cycle in which its selected event is high and it is neither frozen nor held. The 3-bit select field of counter k (k = 1..6) sits in bits [3k-1:3k-3] of address 1. Code 0 selects the address match, code 1 selects the threshold event, and code c = 2..7 selects `ext_ev[c-2]`. Counters sit at addresses 2..7 (counter 1 at 2).
- R3: A write to a counter in the same cycle as an increment loads the written value. Each written register reads back its value: mode at address 0, breakpoint at 8, mask at 9.
- R4: Mode bit 0 stops all counting. Bit 1 stops counting while `priv_sup` is 1. Bit 2 stops it while `priv_sup` is 0. Bit 3 stops it while `pmark` is 1. Bit 4 stops it while `pmark` is 0.
- R5: The threshold event is high when `lat_vld` is 1 and `lat_val` is greater than the 6-bit mode field [17:12] times 2 (mode bit 11 = 0) or times 32 (mode bit 11 = 1).
- R6: The address-match event is high when `iaddr_vld` is 1 and `iaddr` equals the breakpoint on every bit where the mask is 1.
- R7: With mode bit 9 set, counters 2 to 6 hold until counter 1 has overflowed or an interrupt has been raised. Counter 1 keeps counting.
- R8: `pm_int` goes high one edge after the unit sees a source that is enabled while the global enable (mode bit 5) is set. The sources are: counter 1 overflow with bit 7, overflow of any of counters 2 to 6 with bit 8, or a time-base rise with bit 10. `pm_int` stays high until the mode register is written, and that write clears it.
- R9: With mode bit 6 set, no counter changes while `pm_int` is high.
- R10: A time-base rise is reported in the cycle in which `tbase[mode[23:18]]` is 1 and was 0 in the cycle before. A steady 1 or a falling bit reports nothing.
- R11: `pm_cond` is high in any cycle in which a counter has overflowed, the threshold event is high or a time-base rise is seen, whatever the interrupt enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 32 | Read data, combinational |
| ext_ev | input | 6 | External event strobes |
| priv_sup | input | 1 | Current privilege is supervisor |
| pmark | input | 1 | Process-mark bit |
| iaddr | input | 30 | Instruction address to compare |
| iaddr_vld | input | 1 | Instruction address is valid |
| lat_val | input | 12 | Latency or duration value |
| lat_vld | input | 1 | Latency value is valid |
| tbase | input | 64 | Time base |
| pm_int | output | 1 | Sticky monitor interrupt |
| pm_cond | output | 1 | Condition indicator, independent of enables |

## Verification
The threshold table walks both multipliers at the limit value and one above it. A unit that compared with greater-or-equal, or swapped the scale factors, would light `pm_cond` on the wrong entry. Directed tests collide a counter write with an event in the same cycle, where a wrong priority leaves the counter one higher. They also run the trigger chain across the counter 1 overflow, where a missing hold lets counter 2 count too early. A mode write must clear a pending interrupt, and counter 2 overflow must not raise one when only the counter 1 enable is set. A time-base bit that stays high must report exactly one rise, not a level.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

   typedef struct packed {
      logic [5:0] tb_sel;     // [23:18] time-base bit selector
      logic [5:0] thr;        // [17:12] threshold value
      logic       thr_x32;    // [11] multiplier: 0 -> x2, 1 -> x32
      logic       tb_ie;      // [10] time-base rise interrupt enable
      logic       trig;       // [9] hold counters 2.. until trigger
      logic       cn_ie;      // [8] overflow enable counters 2..
      logic       c1_ie;      // [7] overflow enable counter 1
      logic       frz_on_int; // [6] stop counting once interrupt raised
      logic       int_en;     // [5] global interrupt signalling
      logic       frz_mk0;    // [4] stop while mark clear
      logic       frz_mk1;    // [3] stop while mark set
      logic       frz_usr;    // [2] stop in user mode
      logic       frz_sup;    // [1] stop in supervisor mode
      logic       frz_all;    // [0] stop unconditionally
   } mode_t;

   localparam int MODE_W   = $bits(mode_t);
   localparam int TB_W     = 64;
   localparam int ADR_MODE = 0;
   localparam int ADR_SEL  = 1;
   localparam int ADR_CNT0 = 2;

endpackage

// File: rtl/evmon_cnt.sv
module evmon_cnt #(
   parameter int CNT_W  = 32,
   parameter int NUM_EV = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic [SEL_W-1:0]  sel,
   input  logic [NUM_EV-1:0] ev_vec,
   input  logic              en,
   output logic [CNT_W-1:0]  q
);

   logic hit;

   if (SEL_W != $clog2(NUM_EV)) begin : g_bad_sel
      $error("evmon_cnt: SEL_W must equal clog2(NUM_EV)");
   end

   if (NUM_EV == (2 ** SEL_W)) begin : g_full_sel
      always_comb hit = ev_vec[sel];
   end else begin : g_part_sel
      always_comb hit = (int'(sel) < NUM_EV) ? ev_vec[sel] : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr) begin
         q <= wdata;
      end else if (en && hit) begin
         q <= q + 1'b1;
      end
   end

   AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(wdata)));                             // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !(en && hit)) |=> $stable(q));                   // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && en && hit) |=> (q == $past(q) + 1'b1));          // R2

endmodule

// File: rtl/evmon_evsrc.sv
module evmon_evsrc #(
   parameter int ADDR_W  = 30,
   parameter int LAT_W   = 12,
   parameter int NUM_EXT = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [5:0]                thr,
   input  logic                      thr_x32,
   input  logic [5:0]                tb_sel,
   input  logic [ADDR_W-1:0]         bkpt,
   input  logic [ADDR_W-1:0]         mask,
   input  logic [ADDR_W-1:0]         iaddr,
   input  logic                      iaddr_vld,
   input  logic [LAT_W-1:0]          lat_val,
   input  logic                      lat_vld,
   input  logic [evmon_pkg::TB_W-1:0] tbase,
   input  logic [NUM_EXT-1:0]        ext_ev,
   output logic [NUM_EXT+1:0]        ev_vec,
   output logic                      tb_rise,
   output logic                      thr_hit
);

   localparam int LIM_W = 6 + 5;
   localparam int CMP_W = (LAT_W > LIM_W) ? LAT_W : LIM_W;

   logic [CMP_W-1:0] lim;
   logic             amatch;
   logic             tb_bit;
   logic             tb_prev;

   always_comb begin
      if (thr_x32) lim = CMP_W'(thr) << 5;
      else         lim = CMP_W'(thr) << 1;
   end

   assign thr_hit = lat_vld && (CMP_W'(lat_val) > lim);
   assign amatch  = iaddr_vld && (((bkpt ^ iaddr) & mask) == '0);
   assign tb_bit  = tbase[tb_sel];
   assign tb_rise = tb_bit && !tb_prev;
   assign ev_vec  = {ext_ev, thr_hit, amatch};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tb_prev <= 1'b0;
      else        tb_prev <= tb_bit;
   end

   AST_THR_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      thr_hit |-> lat_vld);                                   // R5
   AST_TB_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_rise && $stable(tb_sel)) |=> (!tb_rise || $changed(tb_sel))); // R10

endmodule

// File: rtl/evmon_ctl.sv
module evmon_ctl #(
   parameter int NUM_CNT = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  evmon_pkg::mode_t     mode,
   input  logic                 mode_wr,
   input  logic                 priv_sup,
   input  logic                 pmark,
   input  logic [NUM_CNT-1:0]   cnt_msb,
   input  logic                 tb_rise,
   input  logic                 thr_hit,
   output logic [NUM_CNT-1:0]   cnt_en,
   output logic                 int_q,
   output logic                 cond
);

   logic freeze;
   logic rel_q;
   logic release_c;
   logic int_set;
   logic unused_fields;

   assign unused_fields = ^{mode.tb_sel, mode.thr, mode.thr_x32};

   always_comb begin
      freeze = mode.frz_all
             | (mode.frz_sup    &  priv_sup)
             | (mode.frz_usr    & ~priv_sup)
             | (mode.frz_mk1    &  pmark)
             | (mode.frz_mk0    & ~pmark)
             | (mode.frz_on_int &  int_q);
   end

   assign release_c = !mode.trig || rel_q || cnt_msb[0] || int_q;

   assign cnt_en[0] = !freeze;
   for (genvar i = 1; i < NUM_CNT; i++) begin : g_en
      assign cnt_en[i] = !freeze && release_c;
   end

   assign int_set = mode.int_en &&
                    ((mode.c1_ie && cnt_msb[0]) ||
                     (mode.cn_ie && (|cnt_msb[NUM_CNT-1:1])) ||
                     (mode.tb_ie && tb_rise));

   assign cond = (|cnt_msb) || tb_rise || thr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q <= 1'b0;
         int_q <= 1'b0;
      end else if (mode_wr) begin
         rel_q <= 1'b0;
         int_q <= 1'b0;
      end else begin
         rel_q <= rel_q || (mode.trig && (cnt_msb[0] || int_q));
         int_q <= int_q || int_set;
      end
   end

   AST_FRZ_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      mode.frz_all |-> (cnt_en == '0));                         // R4
   AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (int_q && !mode_wr) |=> int_q);                           // R8
   AST_NO_INT_WO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.int_en && !int_q) |=> !int_q);                     // R8
   AST_FRZ_ON_INT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.frz_on_int && int_q) |-> (cnt_en == '0));           // R9

endmodule

// File: rtl/evmon_unit.sv
module evmon_unit #(
   parameter int NUM_CNT = 6,
   parameter int CNT_W   = 32,
   parameter int NUM_EXT = 6,
   parameter int ADDR_W  = 30,
   parameter int LAT_W   = 12,
   parameter int REG_W   = 32,
   parameter int RA_W    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [RA_W-1:0]           reg_waddr,
   input  logic [REG_W-1:0]          reg_wdata,
   input  logic [RA_W-1:0]           reg_raddr,
   output logic [REG_W-1:0]          reg_rdata,
   input  logic [NUM_EXT-1:0]        ext_ev,
   input  logic                      priv_sup,
   input  logic                      pmark,
   input  logic [ADDR_W-1:0]         iaddr,
   input  logic                      iaddr_vld,
   input  logic [LAT_W-1:0]          lat_val,
   input  logic                      lat_vld,
   input  logic [63:0]               tbase,
   output logic                      pm_int,
   output logic                      pm_cond
);
   import evmon_pkg::*;

   localparam int NUM_EV   = NUM_EXT + 2;
   localparam int SEL_W    = $clog2(NUM_EV);
   localparam int SELS_W   = NUM_CNT * SEL_W;
   localparam int ADR_BKPT = ADR_CNT0 + NUM_CNT;
   localparam int ADR_MASK = ADR_BKPT + 1;

   if (NUM_CNT < 2 || ADR_MASK >= (2 ** RA_W)) begin : g_bad_cnt
      $error("evmon_unit: NUM_CNT does not fit the register address space");
   end
   if (CNT_W > REG_W || ADDR_W > REG_W || MODE_W > REG_W || SELS_W > REG_W) begin : g_bad_w
      $error("evmon_unit: a register is wider than REG_W");
   end

   mode_t                mode_q;
   logic [MODE_W-1:0]    mode_bits;
   logic [SELS_W-1:0]    sel_q;
   logic [ADDR_W-1:0]    bkpt_q;
   logic [ADDR_W-1:0]    mask_q;
   logic                 mode_wr;
   logic [CNT_W-1:0]     cnt_q [NUM_CNT];
   logic [NUM_CNT-1:0]   cnt_msb;
   logic [NUM_CNT-1:0]   cnt_en;
   logic [NUM_EV-1:0]    ev_vec;
   logic                 tb_rise;
   logic                 thr_hit;

   assign mode_wr   = reg_wr && (reg_waddr == RA_W'(ADR_MODE));
   assign mode_bits = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         sel_q  <= '0;
         bkpt_q <= '0;
         mask_q <= '0;
      end else if (reg_wr) begin
         if (reg_waddr == RA_W'(ADR_MODE)) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
         if (reg_waddr == RA_W'(ADR_SEL))  sel_q  <= reg_wdata[SELS_W-1:0];
         if (reg_waddr == RA_W'(ADR_BKPT)) bkpt_q <= reg_wdata[ADDR_W-1:0];
         if (reg_waddr == RA_W'(ADR_MASK)) mask_q <= reg_wdata[ADDR_W-1:0];
      end
   end

   evmon_evsrc #(
      .ADDR_W (ADDR_W),
      .LAT_W  (LAT_W),
      .NUM_EXT(NUM_EXT)
   ) i_evsrc (
      .clk      (clk),
      .rst_n    (rst_n),
      .thr      (mode_q.thr),
      .thr_x32  (mode_q.thr_x32),
      .tb_sel   (mode_q.tb_sel),
      .bkpt     (bkpt_q),
      .mask     (mask_q),
      .iaddr    (iaddr),
      .iaddr_vld(iaddr_vld),
      .lat_val  (lat_val),
      .lat_vld  (lat_vld),
      .tbase    (tbase),
      .ext_ev   (ext_ev),
      .ev_vec   (ev_vec),
      .tb_rise  (tb_rise),
      .thr_hit  (thr_hit)
   );

   evmon_ctl #(
      .NUM_CNT(NUM_CNT)
   ) i_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .mode_wr (mode_wr),
      .priv_sup(priv_sup),
      .pmark   (pmark),
      .cnt_msb (cnt_msb),
      .tb_rise (tb_rise),
      .thr_hit (thr_hit),
      .cnt_en  (cnt_en),
      .int_q   (pm_int),
      .cond    (pm_cond)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      evmon_cnt #(
         .CNT_W (CNT_W),
         .NUM_EV(NUM_EV),
         .SEL_W (SEL_W)
      ) i_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (reg_wr && (reg_waddr == RA_W'(ADR_CNT0 + i))),
         .wdata (reg_wdata[CNT_W-1:0]),
         .sel   (sel_q[i*SEL_W +: SEL_W]),
         .ev_vec(ev_vec),
         .en    (cnt_en[i]),
         .q     (cnt_q[i])
      );
      assign cnt_msb[i] = cnt_q[i][CNT_W-1];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_raddr == RA_W'(ADR_MODE)) reg_rdata = REG_W'(mode_bits);
      if (reg_raddr == RA_W'(ADR_SEL))  reg_rdata = REG_W'(sel_q);
      if (reg_raddr == RA_W'(ADR_BKPT)) reg_rdata = REG_W'(bkpt_q);
      if (reg_raddr == RA_W'(ADR_MASK)) reg_rdata = REG_W'(mask_q);
      for (int i = 0; i < NUM_CNT; i++) begin
         if (reg_raddr == RA_W'(ADR_CNT0 + i)) reg_rdata = REG_W'(cnt_q[i]);
      end
   end

   AST_MODE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> !pm_int);                                     // R8
   AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.trig && !pm_int && !cnt_msb[0] && !reg_wr && $past(!cnt_msb[0] && !pm_int))
      |=> $stable(cnt_q[1]));                                   // R7

endmodule

// File: tb/test_evmon_unit.sv
module test_evmon_unit;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [3:0]  reg_waddr;
   logic [31:0] reg_wdata;
   logic [3:0]  reg_raddr;
   logic [31:0] reg_rdata;
   logic [5:0]  ext_ev;
   logic        priv_sup;
   logic        pmark;
   logic [29:0] iaddr;
   logic        iaddr_vld;
   logic [11:0] lat_val;
   logic        lat_vld;
   logic [63:0] tbase;
   logic        pm_int;
   logic        pm_cond;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   evmon_unit i_evmon_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr),
      .reg_rdata(reg_rdata),
      .ext_ev   (ext_ev),
      .priv_sup (priv_sup),
      .pmark    (pmark),
      .iaddr    (iaddr),
      .iaddr_vld(iaddr_vld),
      .lat_val  (lat_val),
      .lat_vld  (lat_vld),
      .tbase    (tbase),
      .pm_int   (pm_int),
      .pm_cond  (pm_cond)
   );

   // {vld, thr[5:0], x32, lat[11:0], expected}
   localparam logic [20:0] VEC [10] = '{
      {1'b1, 6'd10, 1'b0, 12'd20,   1'b0},
      {1'b1, 6'd10, 1'b0, 12'd21,   1'b1},
      {1'b1, 6'd10, 1'b1, 12'd320,  1'b0},
      {1'b1, 6'd10, 1'b1, 12'd321,  1'b1},
      {1'b1, 6'd0,  1'b0, 12'd0,    1'b0},
      {1'b1, 6'd0,  1'b0, 12'd1,    1'b1},
      {1'b1, 6'd63, 1'b1, 12'd2016, 1'b0},
      {1'b1, 6'd63, 1'b1, 12'd2017, 1'b1},
      {1'b0, 6'd63, 1'b0, 12'd4095, 1'b0},
      {1'b1, 6'd63, 1'b0, 12'd127,  1'b1}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
      reg_raddr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic pulse(input logic [5:0] m);
      ext_ev = m;
      @(negedge clk);
      ext_ev = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=1 exp=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
      ext_ev = '0; priv_sup = 1'b0; pmark = 1'b0; iaddr = '0; iaddr_vld = 1'b0;
      lat_val = '0; lat_vld = 1'b0; tbase = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 10; a++) rdchk("R1 reg", 4'(a), 32'h0);
      check("R1 pm_int", pm_int, 0);
      check("R1 pm_cond", pm_cond, 0);

      // R5 threshold table
      for (int k = 0; k < 10; k++) begin
         wr(4'd0, (32'(VEC[k][19:14]) << 12) | (32'(VEC[k][13]) << 11));
         lat_vld = VEC[k][20];
         lat_val = VEC[k][12:1];
         #1;
         check("R5 threshold", pm_cond, VEC[k][0]);
         lat_vld = 1'b0; lat_val = '0;
      end
      wr(4'd0, 32'h0);

      // R2 counting: counter1 <- ext_ev[0] (code 2), counter2 <- ext_ev[1] (code 3)
      wr(4'd1, 32'd2 | (32'd3 << 3));
      ext_ev = 6'b000001;
      repeat (3) @(negedge clk);
      ext_ev = '0;
      rdchk("R2 cnt1 x3", 4'd2, 32'd3);
      rdchk("R2 cnt2 idle", 4'd3, 32'd0);
      pulse(6'b000010);
      rdchk("R2 cnt2 one", 4'd3, 32'd1);
      pulse(6'b000011);
      rdchk("R2 cnt1 both", 4'd2, 32'd4);
      rdchk("R2 cnt2 both", 4'd3, 32'd2);

      // R3 write beats increment, readback
      ext_ev = 6'b000001; reg_wr = 1'b1; reg_waddr = 4'd2; reg_wdata = 32'd100;
      @(negedge clk);
      reg_wr = 1'b0; ext_ev = '0;
      rdchk("R3 write priority", 4'd2, 32'd100);
      wr(4'd8, 32'h1234_5678);
      rdchk("R3 bkpt readback", 4'd8, 32'h1234_5678);
      wr(4'd0, 32'h0000_0800);
      rdchk("R3 mode readback", 4'd0, 32'h0000_0800);

      // R4 freeze conditions
      wr(4'd0, 32'h2); priv_sup = 1'b1; pulse(6'b1);
      rdchk("R4 frz sup", 4'd2, 32'd100);
      priv_sup = 1'b0; pulse(6'b1);
      rdchk("R4 frz sup user counts", 4'd2, 32'd101);
      wr(4'd0, 32'h4); pulse(6'b1);
      rdchk("R4 frz usr", 4'd2, 32'd101);
      wr(4'd0, 32'h8); pmark = 1'b1; pulse(6'b1);
      rdchk("R4 frz mark1", 4'd2, 32'd101);
      pmark = 1'b0; pulse(6'b1);
      rdchk("R4 mark0 counts", 4'd2, 32'd102);
      wr(4'd0, 32'h10); pulse(6'b1);
      rdchk("R4 frz mark0", 4'd2, 32'd102);
      wr(4'd0, 32'h1); pulse(6'b1);
      rdchk("R4 frz all", 4'd2, 32'd102);
      wr(4'd0, 32'h0);

      // R6 address match: counter1 code 0
      wr(4'd1, 32'd0 | (32'd3 << 3));
      wr(4'd8, 32'h0ABC_DEF0);
      wr(4'd9, 32'h3FFF_FF00);
      iaddr = 30'h0ABC_DE55; iaddr_vld = 1'b1;
      @(negedge clk); iaddr_vld = 1'b0;
      rdchk("R6 masked match", 4'd2, 32'd103);
      iaddr = 30'h0ABD_DEF0; iaddr_vld = 1'b1;
      @(negedge clk); iaddr_vld = 1'b0;
      rdchk("R6 mismatch", 4'd2, 32'd103);
      iaddr = 30'h0ABC_DEF0;
      @(negedge clk);
      rdchk("R6 not valid", 4'd2, 32'd103);

      // R7 trigger hold
      wr(4'd1, 32'd2 | (32'd3 << 3));
      wr(4'd0, 32'h200);
      pulse(6'b000010);
      rdchk("R7 cnt2 held", 4'd3, 32'd2);
      wr(4'd2, 32'h7FFF_FFFF);
      pulse(6'b000001);
      rdchk("R7 cnt1 counts", 4'd2, 32'h8000_0000);
      pulse(6'b000010);
      rdchk("R7 cnt2 released", 4'd3, 32'd3);
      check("R11 cond no enable", pm_cond, 1);
      check("R8 no int w/o enable", pm_int, 0);

      // R8 interrupt from counter 1
      wr(4'd0, 32'h20 | 32'h80);
      check("R8 cleared by write", pm_int, 0);
      @(negedge clk);
      check("R8 int set", pm_int, 1);
      @(negedge clk);
      check("R8 int sticky", pm_int, 1);

      // R9 freeze on interrupt
      wr(4'd0, 32'h20 | 32'h80 | 32'h40);
      @(negedge clk);
      check("R9 int raised", pm_int, 1);
      pulse(6'b000011);
      rdchk("R9 cnt2 frozen", 4'd3, 32'd3);
      rdchk("R9 cnt1 frozen", 4'd2, 32'h8000_0000);

      // R8 per-source enables
      wr(4'd0, 32'h0);
      check("R8 write clears", pm_int, 0);
      wr(4'd2, 32'h0);
      wr(4'd3, 32'h8000_0000);
      wr(4'd0, 32'h20 | 32'h80);
      @(negedge clk);
      check("R8 cnt2 ovf needs cn enable", pm_int, 0);
      wr(4'd0, 32'h20 | 32'h100);
      @(negedge clk);
      check("R8 cnt2 ovf int", pm_int, 1);
      wr(4'd3, 32'h0);
      wr(4'd0, 32'h0);

      // R10 time-base rise on bit 5
      wr(4'd0, (32'd5 << 18) | 32'h400 | 32'h20);
      check("R10 quiet", pm_cond, 0);
      tbase = 64'h20;
      #1;
      check("R10 rise cond", pm_cond, 1);
      @(negedge clk);
      check("R10 rise int", pm_int, 1);
      check("R10 steady no rise", pm_cond, 0);
      tbase = 64'h0;
      #1;
      check("R10 fall no rise", pm_cond, 0);
      @(negedge clk);
      wr(4'd0, (32'd63 << 18) | 32'h400);
      tbase = 64'h8000_0000_0000_0000;
      #1;
      check("R11 rise without int enable", pm_cond, 1);
      @(negedge clk);
      check("R8 no int w/o global enable", pm_int, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule